// File: doc/BRIEF.md
# Flash Write-Protection Command Interface

This block is the synchronous bus front end of a 256K x 16 NOR-style flash array model. It samples the chip-enable, write-enable and output-enable strobes together with the address and data buses on every clock edge. From these samples it decides which bus writes are real. It follows the unlock command sequences that guard program and erase, and it turns a completed sequence into a one-cycle request to the array. The request carries the target address and data word.

Two further inputs can stop a request. A write-protect pin locks an 8 K-word boot block, which sits at the top or the bottom of the address space as a parameter selects. A digital low-supply flag blocks all writes. The device reset pin has two effects. A short low pulse on it only blocks writes. A low pulse that lasts at least a set number of cycles clears any partly entered command and aborts the array's operation. After such a reset, the read-ready flag stays low for a set recovery delay.

Top module: `fwp_cmd_if`

## Requirements
- R1: A bus write counts only while chip-enable and write-enable are both low. It is discarded if output-enable is low, or the reset pin is low, in any cycle of the strobe or in the cycle the strobe ends.
- R2: A strobe that stays low for fewer than MIN_PULSE clock cycles is discarded, and the command tracker keeps its state. A strobe of MIN_PULSE cycles or longer is accepted when it ends.
- R3: A program request is raised only after this order of writes: 0x5555/0xAA, then 0x2AAA/0x55, then 0x5555/0xA0, then one write whose address and data are the target. Only the low data byte is compared in command writes.
- R4: An erase request is raised only after six writes: 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x80, 0x5555/0xAA, 0x2AAA/0x55, then a final write. A final write of 0x10 at 0x5555 gives a chip erase (erase_chip=1). A final write of 0x30 at any address gives a sector erase at that address (erase_chip=0).
- R5: Any accepted write that does not match the next step of a sequence returns the tracker to idle and raises no request.
- R6: While wp_n is low, program requests and sector erases whose address falls in the boot block are dropped. With BOOT_TOP=1 the boot block is 0x3E000 to 0x3FFFF; with BOOT_TOP=0 it is 0x00000 to 0x01FFF. While wp_n is high, these requests pass.
- R7: A chip erase always issues erase_req. keep_boot is 1 when wp_n was low, so the array spares the boot block, and 0 otherwise.
- R8: While low_vdd is high, every bus write is discarded.
- R9: A low pulse on dev_rst_n of at least RST_MIN cycles returns the tracker to idle, and the partial sequence is not resumed. op_abort pulses for one cycle if array_busy was high. A shorter low pulse leaves the tracker state intact. read_ready is low while dev_rst_n is low.
- R10: After a qualifying reset is released, read_ready stays low for at least RECOVERY cycles and rises within RECOVERY+3 cycles. read_ready is also low while array_busy is high.
- R11: prog_req and erase_req are single-cycle pulses that present req_addr and req_data of the final write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sys_rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Word address |
| data | input | DATA_W | Write data |
| wp_n | input | 1 | Boot-block write protect, active low |
| dev_rst_n | input | 1 | Device reset pin, active low |
| low_vdd | input | 1 | Supply undervoltage inhibit |
| array_busy | input | 1 | Array reports an operation in progress |
| prog_req | output | 1 | Program request pulse |
| erase_req | output | 1 | Erase request pulse |
| erase_chip | output | 1 | Erase is a chip erase |
| keep_boot | output | 1 | Chip erase must spare the boot block |
| req_addr | output | ADDR_W | Request address |
| req_data | output | DATA_W | Request data |
| op_abort | output | 1 | Abort pulse for the array operation |
| read_ready | output | 1 | Reads may be performed |

## Verification
The bench builds two instances on the same stimulus, one with BOOT_TOP=1 and one with BOOT_TOP=0. A single program write can therefore be dropped by one instance and accepted by the other, which shows that the boot-range decode depends on the parameter. MIN_PULSE=3 lets a two-cycle glitch be placed in the middle of a command sequence. RST_MIN=4 lets short and qualifying reset pulses differ by a single cycle. RECOVERY=12 keeps the recovery window short enough to measure cycle by cycle.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_U1, ST_U2, ST_PGM, ST_E1, ST_E2, ST_E3
  } seq_st_t;

  typedef enum logic [1:0] {CMD_PROG, CMD_CHIP, CMD_SECT} cmd_kind_t;

  localparam logic [7:0] KEY_A     = 8'hAA;
  localparam logic [7:0] KEY_B     = 8'h55;
  localparam logic [7:0] OP_PROG   = 8'hA0;
  localparam logic [7:0] OP_ERASE  = 8'h80;
  localparam logic [7:0] OP_CHIP   = 8'h10;
  localparam logic [7:0] OP_SECT   = 8'h30;
  localparam int unsigned CMD_ADDR1 = 32'h5555;
  localparam int unsigned CMD_ADDR2 = 32'h2AAA;
endpackage

// File: rtl/fwp_strobe_filter.sv
module fwp_strobe_filter #(
  parameter int unsigned ADDR_W    = 18,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned MIN_PULSE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              low_vdd,
  input  logic              dev_rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int unsigned CW = $clog2(MIN_PULSE + 1);
  localparam logic [CW-1:0] MINV = CW'(MIN_PULSE);

  logic              strobe, inhibit;
  logic              act_q, poison_q;
  logic [CW-1:0]     cnt_q;
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_data;

  assign strobe  = !ce_n && !we_n;
  assign inhibit = !oe_n || low_vdd || !dev_rst_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q    <= 1'b0;
      poison_q <= 1'b0;
      cnt_q    <= '0;
      cap_addr <= '0;
      cap_data <= '0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_valid <= 1'b0;
      if (strobe) begin
        act_q    <= 1'b1;
        cap_addr <= addr;
        cap_data <= data;
        if (cnt_q != MINV) cnt_q <= cnt_q + 1'b1;
        if (inhibit) poison_q <= 1'b1;
      end else begin
        act_q    <= 1'b0;
        poison_q <= 1'b0;
        cnt_q    <= '0;
        if (act_q && !poison_q && !inhibit && cnt_q == MINV) begin
          wr_valid <= 1'b1;
          wr_addr  <= cap_addr;
          wr_data  <= cap_data;
        end
      end
    end
  end

  // R1 / R8: an accepted write never ends while an inhibit condition holds
  a_r1_inhibit_at_end: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> ($past(oe_n) && !$past(low_vdd) && $past(dev_rst_n)));

  // R2: an accepted write follows the end of a strobe
  a_r2_after_strobe_end: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> (!$past(strobe) && $past(act_q)));

  a_r2_isolated: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> !wr_valid);
endmodule

// File: rtl/fwp_seq_tracker.sv
module fwp_seq_tracker
  import fwp_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              cmd_valid,
  output cmd_kind_t         cmd_kind,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data
);
  seq_st_t    state;
  logic       at1, at2;
  logic [7:0] lo;

  assign at1 = (wr_addr == ADDR_W'(CMD_ADDR1));
  assign at2 = (wr_addr == ADDR_W'(CMD_ADDR2));
  assign lo  = wr_data[7:0];

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      state     <= ST_IDLE;
      cmd_valid <= 1'b0;
      cmd_kind  <= CMD_PROG;
      cmd_addr  <= '0;
      cmd_data  <= '0;
    end else begin
      cmd_valid <= 1'b0;
      if (wr_valid) begin
        state <= ST_IDLE;
        unique case (state)
          ST_IDLE: if (at1 && lo == KEY_A) state <= ST_U1;
          ST_U1:   if (at2 && lo == KEY_B) state <= ST_U2;
          ST_U2: begin
            if (at1 && lo == OP_PROG)       state <= ST_PGM;
            else if (at1 && lo == OP_ERASE) state <= ST_E1;
          end
          ST_PGM: begin
            cmd_valid <= 1'b1;
            cmd_kind  <= CMD_PROG;
            cmd_addr  <= wr_addr;
            cmd_data  <= wr_data;
          end
          ST_E1: if (at1 && lo == KEY_A) state <= ST_E2;
          ST_E2: if (at2 && lo == KEY_B) state <= ST_E3;
          ST_E3: begin
            cmd_addr <= wr_addr;
            cmd_data <= wr_data;
            if (at1 && lo == OP_CHIP) begin
              cmd_valid <= 1'b1;
              cmd_kind  <= CMD_CHIP;
            end else if (lo == OP_SECT) begin
              cmd_valid <= 1'b1;
              cmd_kind  <= CMD_SECT;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R3: program command issued only from the data-load step
  a_r3_prog_from_load: assert property (@(posedge clk) disable iff (rst || clear)
    (cmd_valid && cmd_kind == CMD_PROG) |-> ($past(state) == ST_PGM && $past(wr_valid)));

  // R4: erase command issued only from the sixth step
  a_r4_erase_from_sixth: assert property (@(posedge clk) disable iff (rst || clear)
    (cmd_valid && cmd_kind != CMD_PROG) |-> ($past(state) == ST_E3 && $past(wr_valid)));

  // R5: a write that breaks the unlock prefix leaves the tracker idle
  a_r5_break_to_idle: assert property (@(posedge clk) disable iff (rst || clear)
    (wr_valid && state == ST_U1 && !(at2 && lo == KEY_B)) |=> (state == ST_IDLE && !cmd_valid));
endmodule

// File: rtl/fwp_reset_ctrl.sv
module fwp_reset_ctrl #(
  parameter int unsigned RST_MIN  = 20,
  parameter int unsigned RECOVERY = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic dev_rst_n,
  input  logic array_busy,
  output logic seq_clear,
  output logic op_abort,
  output logic read_ready
);
  localparam int unsigned LW = $clog2(RST_MIN + 1);
  localparam int unsigned RW = $clog2(RECOVERY + 1);
  localparam logic [LW-1:0] LOW_LAST = LW'(RST_MIN - 1);
  localparam logic [RW-1:0] RECV     = RW'(RECOVERY);

  logic [LW-1:0] low_cnt;
  logic [RW-1:0] rec_cnt;
  logic          qual_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt    <= '0;
      rec_cnt    <= RECV;
      qual_q     <= 1'b0;
      seq_clear  <= 1'b0;
      op_abort   <= 1'b0;
      read_ready <= 1'b0;
    end else begin
      seq_clear <= 1'b0;
      op_abort  <= 1'b0;
      if (!dev_rst_n) begin
        if (!qual_q) begin
          if (low_cnt == LOW_LAST) begin
            qual_q    <= 1'b1;
            seq_clear <= 1'b1;
            op_abort  <= array_busy;
          end else begin
            low_cnt <= low_cnt + 1'b1;
          end
        end
      end else begin
        low_cnt <= '0;
        if (qual_q) begin
          qual_q  <= 1'b0;
          rec_cnt <= RECV;
        end else if (rec_cnt != '0) begin
          rec_cnt <= rec_cnt - 1'b1;
        end
      end
      read_ready <= dev_rst_n && !qual_q && (rec_cnt == '0) && !array_busy;
    end
  end

  // R9: reads are never flagged ready while the reset pin is low
  a_r9_not_ready_in_reset: assert property (@(posedge clk) disable iff (rst)
    !$past(dev_rst_n) |-> !read_ready);

  a_r9_abort_needs_clear: assert property (@(posedge clk) disable iff (rst)
    op_abort |-> seq_clear);

  // R10: ready stays low across the qualified-reset release cycle
  a_r10_hold_after_release: assert property (@(posedge clk) disable iff (rst)
    $past(qual_q) |-> !read_ready);
endmodule

// File: rtl/fwp_cmd_if.sv
module fwp_cmd_if
  import fwp_pkg::*;
#(
  parameter int unsigned ADDR_W     = 18,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned MIN_PULSE  = 2,
  parameter int unsigned RST_MIN    = 20,
  parameter int unsigned RECOVERY   = 10,
  parameter int unsigned BOOT_WORDS = 8192,
  parameter bit          BOOT_TOP   = 1'b1
) (
  input  logic              clk,
  input  logic              sys_rst,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              wp_n,
  input  logic              dev_rst_n,
  input  logic              low_vdd,
  input  logic              array_busy,
  output logic              prog_req,
  output logic              erase_req,
  output logic              erase_chip,
  output logic              keep_boot,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  output logic              op_abort,
  output logic              read_ready
);
  localparam int unsigned BB = $clog2(BOOT_WORDS);

  logic              wr_valid, seq_clear, cmd_valid;
  logic [ADDR_W-1:0] wr_addr, cmd_addr;
  logic [DATA_W-1:0] wr_data, cmd_data;
  cmd_kind_t         cmd_kind;
  logic              cmd_boot;

  function automatic logic in_boot(input logic [ADDR_W-1:0] a);
    if (BOOT_TOP) return &a[ADDR_W-1:BB];
    else          return ~|a[ADDR_W-1:BB];
  endfunction

  fwp_strobe_filter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_PULSE(MIN_PULSE)) u_filt (
    .clk(clk), .rst(sys_rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .low_vdd(low_vdd), .dev_rst_n(dev_rst_n), .addr(addr), .data(data),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  fwp_seq_tracker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst(sys_rst), .clear(seq_clear), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .cmd_valid(cmd_valid),
    .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  fwp_reset_ctrl #(.RST_MIN(RST_MIN), .RECOVERY(RECOVERY)) u_rst (
    .clk(clk), .rst(sys_rst), .dev_rst_n(dev_rst_n), .array_busy(array_busy),
    .seq_clear(seq_clear), .op_abort(op_abort), .read_ready(read_ready)
  );

  assign cmd_boot = in_boot(cmd_addr);

  always_ff @(posedge clk) begin
    if (sys_rst) begin
      prog_req   <= 1'b0;
      erase_req  <= 1'b0;
      erase_chip <= 1'b0;
      keep_boot  <= 1'b0;
      req_addr   <= '0;
      req_data   <= '0;
    end else begin
      prog_req   <= cmd_valid && cmd_kind == CMD_PROG && (wp_n || !cmd_boot);
      erase_req  <= cmd_valid && (cmd_kind == CMD_CHIP ||
                    (cmd_kind == CMD_SECT && (wp_n || !cmd_boot)));
      erase_chip <= cmd_valid && cmd_kind == CMD_CHIP;
      keep_boot  <= cmd_valid && cmd_kind == CMD_CHIP && !wp_n;
      req_addr   <= cmd_addr;
      req_data   <= cmd_data;
    end
  end

  // R6: no boot-block program or sector erase leaves while protected
  a_r6_boot_locked: assert property (@(posedge clk) disable iff (sys_rst)
    (prog_req || (erase_req && !erase_chip)) |-> ($past(wp_n) || !in_boot(req_addr)));

  // R7: the spare-boot flag follows the protect pin for chip erase
  a_r7_keep_boot: assert property (@(posedge clk) disable iff (sys_rst)
    (erase_req && erase_chip) |-> (keep_boot == !$past(wp_n)));

  // R11: requests are single-cycle pulses
  a_r11_prog_pulse: assert property (@(posedge clk) disable iff (sys_rst)
    prog_req |=> !prog_req);

  a_r11_erase_pulse: assert property (@(posedge clk) disable iff (sys_rst)
    erase_req |=> !erase_req);
endmodule

// File: tb/tb_fwp_cmd_if.sv
`timescale 1ns/1ps
module tb_fwp_cmd_if;
  localparam int unsigned AW = 18;
  localparam int unsigned DW = 16;
  localparam int unsigned MINP = 3;
  localparam int unsigned RMIN = 4;
  localparam int unsigned REC = 12;

  logic clk = 1'b0;
  logic sys_rst = 1'b1;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic wp_n = 1'b1, dev_rst_n = 1'b1, low_vdd = 1'b0, array_busy = 1'b0;

  logic prog_req, erase_req, erase_chip, keep_boot, op_abort, read_ready;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_data;
  logic prog_b, erase_b, chip_b, keep_b, abort_b, ready_b;
  logic [AW-1:0] addr_b;
  logic [DW-1:0] data_b;

  int n_chk = 0, n_bad = 0;
  int pc = 0, ec = 0, ac = 0, pcb = 0, ecb = 0, wide = 0;
  logic [AW-1:0] lpa, lea;
  logic [DW-1:0] lpd;
  logic lchip, lkeep, prev_p, prev_e;

  always #2.5 clk = ~clk;

  fwp_cmd_if #(.ADDR_W(AW), .DATA_W(DW), .MIN_PULSE(MINP), .RST_MIN(RMIN),
               .RECOVERY(REC), .BOOT_WORDS(8192), .BOOT_TOP(1'b1)) dut (
    .clk(clk), .sys_rst(sys_rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .data(data), .wp_n(wp_n), .dev_rst_n(dev_rst_n),
    .low_vdd(low_vdd), .array_busy(array_busy), .prog_req(prog_req),
    .erase_req(erase_req), .erase_chip(erase_chip), .keep_boot(keep_boot),
    .req_addr(req_addr), .req_data(req_data), .op_abort(op_abort),
    .read_ready(read_ready));

  fwp_cmd_if #(.ADDR_W(AW), .DATA_W(DW), .MIN_PULSE(MINP), .RST_MIN(RMIN),
               .RECOVERY(REC), .BOOT_WORDS(8192), .BOOT_TOP(1'b0)) dut_bot (
    .clk(clk), .sys_rst(sys_rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .data(data), .wp_n(wp_n), .dev_rst_n(dev_rst_n),
    .low_vdd(low_vdd), .array_busy(array_busy), .prog_req(prog_b),
    .erase_req(erase_b), .erase_chip(chip_b), .keep_boot(keep_b),
    .req_addr(addr_b), .req_data(data_b), .op_abort(abort_b),
    .read_ready(ready_b));

  always @(negedge clk) begin
    if (!sys_rst) begin
      if (prog_req) begin pc++; lpa = req_addr; lpd = req_data; end
      if (erase_req) begin ec++; lea = req_addr; lchip = erase_chip; lkeep = keep_boot; end
      if (op_abort) ac++;
      if (prog_b) pcb++;
      if (erase_b) ecb++;
      if ((prog_req && prev_p) || (erase_req && prev_e)) wide++;
      prev_p = prog_req;
      prev_e = erase_req;
    end else begin
      prev_p = 1'b0;
      prev_e = 1'b0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input int n = 4,
                    input logic oe = 1'b1);
    @(negedge clk);
    addr = a; data = d; oe_n = oe; ce_n = 1'b0; we_n = 1'b0;
    repeat (n) @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic unlock3(input logic [7:0] op);
    wr(18'h05555, 16'h00AA);
    wr(18'h02AAA, 16'h0055);
    wr(18'h05555, {8'h00, op});
  endtask

  task automatic t_reset_state();
    chk("R10 ready low in reset", {31'b0, read_ready}, 0);
    chk("R11 no request in reset", {30'b0, prog_req, erase_req}, 0);
    @(negedge clk); sys_rst = 1'b0;
    repeat (REC + 4) @(negedge clk);
    chk("R10 ready after power-on recovery", {31'b0, read_ready}, 1);
  endtask

  task automatic t_program();
    int p0 = pc;
    unlock3(8'hA0);
    wr(18'h01234, 16'hBEEF);
    settle();
    chk("R3 program accepted", pc - p0, 1);
    chk("R11 program address", {14'b0, lpa}, 32'h01234);
    chk("R11 program data", {16'b0, lpd}, 32'hBEEF);
    chk("R11 single-cycle pulses", wide, 0);
    // high data byte ignored in command compare
    p0 = pc;
    wr(18'h05555, 16'h12AA); wr(18'h02AAA, 16'hFF55); wr(18'h05555, 16'h00A0);
    wr(18'h00777, 16'h0102);
    settle();
    chk("R3 low-byte command compare", pc - p0, 1);
  endtask

  task automatic t_glitch();
    int p0 = pc;
    wr(18'h05555, 16'h00AA);
    wr(18'h02AAA, 16'h0055);
    wr(18'h01111, 16'h0000, MINP - 1);  // glitch mid-sequence
    wr(18'h05555, 16'h00A0);
    wr(18'h00400, 16'h4444, MINP - 1);  // glitched data write
    settle();
    chk("R2 glitch data ignored", pc - p0, 0);
    wr(18'h00400, 16'h5555, MINP);
    settle();
    chk("R2 min-width write accepted", pc - p0, 1);
    chk("R2 data of full write", {16'b0, lpd}, 32'h5555);
  endtask

  task automatic t_inhibit();
    int p0 = pc;
    unlock3(8'hA0);
    wr(18'h00500, 16'h0001, 4, 1'b0);   // output-enable low
    settle();
    chk("R1 write with OE low ignored", pc - p0, 0);
    @(negedge clk); addr = 18'h00500; data = 16'h0002; we_n = 1'b0;  // CE high
    repeat (4) @(negedge clk); we_n = 1'b1;
    @(negedge clk); addr = 18'h00500; data = 16'h0003; ce_n = 1'b0;  // WE high
    repeat (4) @(negedge clk); ce_n = 1'b1;
    settle();
    chk("R1 single strobe ignored", pc - p0, 0);
    low_vdd = 1'b1;
    wr(18'h00500, 16'h0004);
    low_vdd = 1'b0;
    settle();
    chk("R8 low supply write ignored", pc - p0, 0);
    wr(18'h00500, 16'h0005);
    settle();
    chk("R1 tracker kept state", pc - p0, 1);
    chk("R1 accepted data", {16'b0, lpd}, 32'h0005);
  endtask

  task automatic t_break();
    int p0 = pc;
    wr(18'h05555, 16'h00AA);
    wr(18'h01234, 16'h0055);   // wrong address
    wr(18'h02AAA, 16'h0055);
    wr(18'h05555, 16'h00A0);
    wr(18'h00600, 16'h0006);
    settle();
    chk("R5 broken sequence no program", pc - p0, 0);
  endtask

  task automatic t_boot();
    int p0 = pc, b0 = pcb;
    wp_n = 1'b0;
    unlock3(8'hA0); wr(18'h3E100, 16'h0A0A);
    settle();
    chk("R6 top boot program dropped", pc - p0, 0);
    chk("R6 bottom variant accepts top address", pcb - b0, 1);
    unlock3(8'hA0); wr(18'h00100, 16'h0B0B);
    settle();
    chk("R6 top variant accepts low address", pc - p0, 1);
    chk("R6 bottom boot program dropped", pcb - b0, 1);
    wp_n = 1'b1;
    unlock3(8'hA0); wr(18'h3FFFF, 16'h0C0C);
    settle();
    chk("R6 boot program with wp high", pc - p0, 2);
    chk("R6 boot edge address", {14'b0, lpa}, 32'h3FFFF);
  endtask

  task automatic t_erase();
    int e0 = ec;
    wp_n = 1'b0;
    unlock3(8'h80); wr(18'h05555, 16'h00AA); wr(18'h02AAA, 16'h0055);
    wr(18'h05555, 16'h0010);
    settle();
    chk("R4 chip erase issued", ec - e0, 1);
    chk("R7 keep boot on protected chip erase", {30'b0, lchip, lkeep}, 3);
    unlock3(8'h80); wr(18'h05555, 16'h00AA); wr(18'h02AAA, 16'h0055);
    wr(18'h3E000, 16'h0030);
    settle();
    chk("R6 boot sector erase dropped", ec - e0, 1);
    unlock3(8'h80); wr(18'h05555, 16'h00AA); wr(18'h02AAA, 16'h0055);
    wr(18'h12000, 16'h0030);
    settle();
    chk("R4 sector erase issued", ec - e0, 2);
    chk("R4 sector address", {14'b0, lea}, 32'h12000);
    chk("R4 sector flag", {31'b0, lchip}, 0);
    wp_n = 1'b1;
    unlock3(8'h80); wr(18'h05555, 16'h00AA); wr(18'h02AAA, 16'h0055);
    wr(18'h05555, 16'h0010);
    settle();
    chk("R7 unprotected chip erase", {29'b0, lchip, lkeep, 1'b0} | (ec - e0), 32'h7 & 32'h5 | 3);
    unlock3(8'h80); wr(18'h05555, 16'h00AA); wr(18'h02AAA, 16'h0055);
    wr(18'h05555, 16'h0020);
    settle();
    chk("R5 bad sixth write no erase", ec - e0, 3);
  endtask

  task automatic t_reset_abort();
    int p0 = pc, a0 = ac, k = 0;
    logic seen_hi = 1'b0;
    array_busy = 1'b1;
    wr(18'h05555, 16'h00AA); wr(18'h02AAA, 16'h0055);
    @(negedge clk); dev_rst_n = 1'b0;
    repeat (RMIN) @(negedge clk);
    chk("R9 ready low in reset", {31'b0, read_ready}, 0);
    dev_rst_n = 1'b1; array_busy = 1'b0;
    while (k < REC + 6) begin
      @(negedge clk); k++;
      if (read_ready) break;
      if (k == REC) seen_hi = read_ready;
    end
    chk("R10 ready low through recovery", {31'b0, seen_hi}, 0);
    chk("R10 ready rises within limit", (k >= REC && k <= REC + 3) ? 1 : 0, 1);
    wr(18'h05555, 16'h00A0); wr(18'h00900, 16'h0909);
    settle();
    chk("R9 aborted sequence not resumed", pc - p0, 0);
    chk("R9 abort pulse when busy", ac - a0, 1);
    // short pulse keeps state
    p0 = pc;
    wr(18'h05555, 16'h00AA); wr(18'h02AAA, 16'h0055);
    @(negedge clk); dev_rst_n = 1'b0;
    repeat (RMIN - 1) @(negedge clk);
    dev_rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 short reset keeps ready", {31'b0, read_ready}, 1);
    wr(18'h05555, 16'h00A0); wr(18'h00A00, 16'h0A0A);
    settle();
    chk("R9 short reset keeps sequence", pc - p0, 1);
    chk("R9 no abort on short reset", ac - a0, 1);
    array_busy = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 ready low while busy", {31'b0, read_ready}, 0);
    array_busy = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    t_reset_state();
    t_program();
    t_glitch();
    t_inhibit();
    t_break();
    t_boot();
    t_erase();
    t_reset_abort();
    chk("R11 pulses stayed single-cycle", wide, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule